// File: doc/BRIEF.md
# Register-List Block Transfer Sequencer

This block moves a group of up to eight low registers to memory or from memory in one multi-cycle operation. A one-cycle start pulse supplies the direction, the index of the register that holds the base address, an 8-bit selection mask and the base address itself. The sequencer then walks the mask from the lowest selected register to the highest. It issues one word request per selected register on a request/acknowledge memory port, and the address rises by one word after each accepted transfer.

For stores, the sequencer names the register it needs on a read port of the external register file and forwards the value it gets back as write data. For loads, it writes the returned word into the register file in the same cycle that the memory acknowledges it. When the last word has been transferred, the final address is written back into the base register. The one exception is a load whose mask includes the base register: in that case the loaded word is kept and the writeback is skipped.

Top module: `blkxfer_seq`

## Requirements
- R1: While reset is held and after it is released, busy_o, done_o, mem_req_o and rf_wr_en_o are all low.
- R2: Bit i of the mask selects register i. Exactly one memory request is accepted per set bit, and registers are served in ascending index order.
- R3: The first request uses the base address. Each later request uses the previous address plus 4.
- R4: With dir_load_i = 0 (store), mem_we_o is high and mem_wdata_o carries rf_rd_data_i for the register named on rf_rd_idx_o. Registers in the list are not modified.
- R5: With dir_load_i = 1 (load), in the cycle a request is acknowledged, rf_wr_en_o is high, rf_wr_idx_o names the current register and rf_wr_data_o equals mem_rdata_i.
- R6: An unacknowledged request keeps mem_req_o high and holds its address and register index stable until mem_ack_i arrives.
- R7: In the cycle after the last acknowledge, the base register receives the original base plus 4 times the number of set mask bits. done_o follows in the next cycle.
- R8: An empty mask causes no memory request and no register write, and done_o is high in the cycle after start.
- R9: For a load whose mask includes the base register, the base register ends with the loaded word, and no writeback occurs.
- R10: A start pulse that arrives while busy_o is high is ignored.
- R11: busy_o goes high in the cycle after an accepted start and stays high through the done_o cycle. done_o lasts exactly one cycle, after which busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| dir_load_i | input | 1 | 0 = store to memory, 1 = load from memory |
| base_idx_i | input | 3 | Index of the base register |
| reg_mask_i | input | 8 | Register selection mask, bit i = register i |
| base_addr_i | input | 32 | Current contents of the base register |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Word address of the request |
| mem_wdata_o | output | 32 | Store data |
| mem_rdata_i | input | 32 | Load data, valid with mem_ack_i |
| mem_ack_i | input | 1 | Memory accepts the request this cycle |
| rf_rd_idx_o | output | 3 | Register file read index (current register) |
| rf_rd_data_i | input | 32 | Register file read data |
| rf_wr_en_o | output | 1 | Register file write enable |
| rf_wr_idx_o | output | 3 | Register file write index |
| rf_wr_data_o | output | 32 | Register file write data |

## Verification
The base register can be the target of two different actions in one operation: the word a load brings back for it, and the final address writeback. The second action must give way to the first. This case is provoked with directed and random loads whose mask includes the base index, and with stores that include it. A store must send out the original base value and still write back the new address. Each case is judged by comparing the final register file and memory contents against a bench model that applies the load-wins rule. The other pairing tested is a start pulse that arrives while an operation is running; it is judged by checking that the final state matches the first operation alone.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_WB   = 2'd2,
    ST_DONE = 2'd3
  } xfer_state_e;
endpackage

// File: rtl/blkxfer_rst_sync.sv
// Asynchronous assertion, synchronous two-stage release.
module blkxfer_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n_o = sync_q[1];
endmodule

// File: rtl/blkxfer_pick.sv
// Finds the lowest set bit of the remaining mask.
module blkxfer_pick #(
  parameter int NREG = 8,
  parameter int IW   = $clog2(NREG)
) (
  input  logic [NREG-1:0] mask_i,
  output logic [NREG-1:0] low_oh_o,
  output logic [IW-1:0]   low_idx_o,
  output logic            only_one_o
);
  assign low_oh_o = mask_i & (~mask_i + NREG'(1));

  for (genvar gb = 0; gb < IW; gb++) begin : g_bit
    logic [NREG-1:0] sel;
    for (genvar gi = 0; gi < NREG; gi++) begin : g_ent
      assign sel[gi] = (((gi >> gb) & 1) == 1) ? 1'b1 : 1'b0;
    end
    assign low_idx_o[gb] = |(low_oh_o & sel);
  end

  assign only_one_o = (|mask_i) && (mask_i == low_oh_o);
endmodule

// File: rtl/blkxfer_fsm.sv
module blkxfer_fsm
  import blkxfer_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        list_empty_i,
  input  logic        ack_i,
  input  logic        last_i,
  output xfer_state_e state_o
);
  xfer_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = list_empty_i ? ST_DONE : ST_XFER;
      ST_XFER: if (ack_i && last_i) state_d = ST_WB;
      ST_WB:   state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
  import blkxfer_pkg::*;
#(
  parameter int NREG = 8,
  parameter int IW   = $clog2(NREG),
  parameter int AW   = 32,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            dir_load_i,
  input  logic [IW-1:0]   base_idx_i,
  input  logic [NREG-1:0] reg_mask_i,
  input  logic [AW-1:0]   base_addr_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic [DW-1:0]   mem_rdata_i,
  input  logic            mem_ack_i,
  output logic [IW-1:0]   rf_rd_idx_o,
  input  logic [DW-1:0]   rf_rd_data_i,
  output logic            rf_wr_en_o,
  output logic [IW-1:0]   rf_wr_idx_o,
  output logic [DW-1:0]   rf_wr_data_o
);
  localparam int STEP = DW / 8;

  logic            rst_int_n;
  xfer_state_e     state;
  logic [NREG-1:0] rem_q, rem_d;
  logic [AW-1:0]   addr_q, addr_d;
  logic            dir_q, sup_q;
  logic [IW-1:0]   bidx_q;
  logic [NREG-1:0] low_oh;
  logic [IW-1:0]   cur_idx;
  logic            last_one;
  logic            accept, step, in_xfer, in_wb, reg_en;

  blkxfer_rst_sync u_rst (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_sync_n_o (rst_int_n)
  );

  blkxfer_pick #(.NREG(NREG), .IW(IW)) u_pick (
    .mask_i     (rem_q),
    .low_oh_o   (low_oh),
    .low_idx_o  (cur_idx),
    .only_one_o (last_one)
  );

  blkxfer_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .start_i      (start_i),
    .list_empty_i (reg_mask_i == '0),
    .ack_i        (mem_ack_i),
    .last_i       (last_one),
    .state_o      (state)
  );

  assign in_xfer = (state == ST_XFER);
  assign in_wb   = (state == ST_WB);
  assign accept  = (state == ST_IDLE) && start_i;
  assign step    = in_xfer && mem_ack_i;
  assign reg_en  = accept || step;

  // Next values for the walking mask and address.
  always_comb begin
    rem_d  = rem_q;
    addr_d = addr_q;
    if (accept) begin
      rem_d  = reg_mask_i;
      addr_d = base_addr_i;
    end else if (step) begin
      rem_d  = rem_q & ~low_oh;
      addr_d = addr_q + AW'(STEP);
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rem_q  <= '0;
      addr_q <= '0;
    end else if (reg_en) begin
      rem_q  <= rem_d;
      addr_q <= addr_d;
    end
  end

  // Operation attributes captured at start.
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      dir_q  <= 1'b0;
      sup_q  <= 1'b0;
      bidx_q <= '0;
    end else if (accept) begin
      dir_q  <= dir_load_i;
      sup_q  <= dir_load_i && reg_mask_i[base_idx_i];
      bidx_q <= base_idx_i;
    end
  end

  assign busy_o       = (state != ST_IDLE);
  assign done_o       = (state == ST_DONE);
  assign mem_req_o    = in_xfer;
  assign mem_we_o     = in_xfer && !dir_q;
  assign mem_addr_o   = addr_q;
  assign mem_wdata_o  = (in_xfer && !dir_q) ? rf_rd_data_i : '0;
  assign rf_rd_idx_o  = cur_idx;
  assign rf_wr_en_o   = (step && dir_q) || (in_wb && !sup_q);
  assign rf_wr_idx_o  = in_wb ? bidx_q : cur_idx;
  assign rf_wr_data_o = in_wb ? DW'(addr_q) : mem_rdata_i;
endmodule

// File: rtl/blkxfer_chk.sv
module blkxfer_chk #(
  parameter int NREG = 8,
  parameter int IW   = 3,
  parameter int AW   = 32,
  parameter int DW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic            dir_load_i,
  input logic [IW-1:0]   base_idx_i,
  input logic [NREG-1:0] reg_mask_i,
  input logic [AW-1:0]   base_addr_i,
  input logic            busy_o,
  input logic            done_o,
  input logic            mem_req_o,
  input logic            mem_we_o,
  input logic [AW-1:0]   mem_addr_o,
  input logic [DW-1:0]   mem_wdata_o,
  input logic [DW-1:0]   mem_rdata_i,
  input logic            mem_ack_i,
  input logic [IW-1:0]   rf_rd_idx_o,
  input logic [DW-1:0]   rf_rd_data_i,
  input logic            rf_wr_en_o,
  input logic [IW-1:0]   rf_wr_idx_o,
  input logic [DW-1:0]   rf_wr_data_o
);
  localparam int STEP = DW / 8;

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(rf_rd_idx_o));

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_ack_i |=> !mem_req_o || (mem_addr_o == $past(mem_addr_o) + AW'(STEP)));

  p_idx_rising_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_ack_i |=> !mem_req_o || (rf_rd_idx_o > $past(rf_rd_idx_o)));

  p_empty_list_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o && (reg_mask_i == '0) |=> done_o && !mem_req_o && !rf_wr_en_o);

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o);

  p_load_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_ack_i && !mem_we_o |-> rf_wr_en_o && (rf_wr_data_o == mem_rdata_i)
      && (rf_wr_idx_o == rf_rd_idx_o));

  p_store_nowrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_we_o |-> !rf_wr_en_o && (mem_wdata_o == rf_rd_data_i));

  p_busy_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> busy_o && !done_o);
endmodule

bind blkxfer_seq blkxfer_chk #(.NREG(NREG), .IW(IW), .AW(AW), .DW(DW)) chk_i (.*);

// File: tb/blkxfer_seq_tb_top.sv
module blkxfer_seq_tb_top;
  localparam int NREG = 8;
  localparam int IW   = 3;
  localparam int AW   = 32;
  localparam int DW   = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            start_i, dir_load_i, mem_ack_i;
  logic [IW-1:0]   base_idx_i;
  logic [NREG-1:0] reg_mask_i;
  logic [AW-1:0]   base_addr_i;
  logic [DW-1:0]   mem_rdata_i, rf_rd_data_i;
  logic            busy_o, done_o, mem_req_o, mem_we_o, rf_wr_en_o;
  logic [AW-1:0]   mem_addr_o;
  logic [DW-1:0]   mem_wdata_o, rf_wr_data_o;
  logic [IW-1:0]   rf_rd_idx_o, rf_wr_idx_o;

  always #2 clk = ~clk;

  blkxfer_seq dut_i (.*);

  logic [DW-1:0] rf    [NREG];
  logic [DW-1:0] mem   [256];
  logic [DW-1:0] st_rf [NREG];
  logic [DW-1:0] st_mem[256];
  logic [AW-1:0] st_base;
  logic          load_stage;
  logic          ack_all;
  int            acc_cnt;
  logic          order_bad;
  logic [AW-1:0] exp_addr;
  int            n_chk, n_fail;

  assign rf_rd_data_i = rf[rf_rd_idx_o];

  // Register file and memory models; the only writers of their contents.
  always @(posedge clk) begin
    if (load_stage) begin
      for (int i = 0; i < NREG; i++) rf[i] <= st_rf[i];
      for (int j = 0; j < 256; j++) mem[j] <= st_mem[j];
      acc_cnt   <= 0;
      order_bad <= 1'b0;
      exp_addr  <= st_base;
    end else begin
      if (rf_wr_en_o) rf[rf_wr_idx_o] <= rf_wr_data_o;
      if (mem_req_o && mem_ack_i) begin
        if (mem_we_o) mem[mem_addr_o[9:2]] <= mem_wdata_o;
        if (mem_addr_o != exp_addr) order_bad <= 1'b1;
        exp_addr <= exp_addr + 4;
        acc_cnt  <= acc_cnt + 1;
      end
    end
  end

  // Memory responder, driven away from the active edge.
  always @(negedge clk) begin
    mem_ack_i   = mem_req_o && (ack_all || ($urandom % 3 != 0));
    mem_rdata_i = mem_req_o ? mem[mem_addr_o[9:2]] : '0;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic int popc(input logic [NREG-1:0] m);
    int c = 0;
    for (int i = 0; i < NREG; i++) c += int'(m[i]);
    return c;
  endfunction

  task automatic run(input bit dir, input logic [IW-1:0] bidx,
                     input logic [NREG-1:0] mask, input bit poke);
    logic [DW-1:0] e_rf [NREG];
    logic [DW-1:0] e_mem[256];
    int base_w, k, waitc;
    bit mem_ok;
    base_w = int'($urandom % 120);
    for (int i = 0; i < NREG; i++) st_rf[i] = $urandom;
    st_rf[bidx] = DW'(base_w * 4);
    for (int j = 0; j < 256; j++) st_mem[j] = $urandom;
    st_base = AW'(base_w * 4);
    @(negedge clk) load_stage = 1'b1;
    @(negedge clk) load_stage = 1'b0;

    for (int i = 0; i < NREG; i++) e_rf[i] = st_rf[i];
    for (int j = 0; j < 256; j++) e_mem[j] = st_mem[j];
    k = 0;
    for (int i = 0; i < NREG; i++) begin
      if (mask[i]) begin
        if (dir) e_rf[i] = st_mem[base_w + k];
        else     e_mem[base_w + k] = st_rf[i];
        k++;
      end
    end
    if (mask != '0 && !(dir && mask[bidx])) e_rf[bidx] = st_rf[bidx] + DW'(4 * k);

    start_i = 1'b1; dir_load_i = dir; base_idx_i = bidx;
    reg_mask_i = mask; base_addr_i = st_base;
    @(negedge clk);
    start_i = 1'b0; reg_mask_i = NREG'($urandom); base_idx_i = IW'($urandom);
    dir_load_i = 1'(~dir); base_addr_i = $urandom;
    if (mask == '0) check(done_o === 1'b1, "R8", "done after empty start", 64'(done_o), 64'd1);
    else            check(busy_o === 1'b1, "R11", "busy after start", 64'(busy_o), 64'd1);
    if (poke) begin
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    waitc = 0;
    while (done_o !== 1'b1 && waitc < 300) begin
      @(negedge clk);
      waitc++;
    end
    check(waitc < 300, "R11", "done reached", 64'(waitc), 64'd0);
    check(acc_cnt == k, (mask == '0) ? "R8" : "R2", "access count", 64'(acc_cnt), 64'(k));
    check(order_bad == 1'b0, "R3", "address sequence", 64'(order_bad), 64'd0);
    for (int i = 0; i < NREG; i++) begin
      string tag;
      if (poke) tag = "R10";
      else if (i == int'(bidx) && mask != '0) tag = (dir && mask[bidx]) ? "R9" : "R7";
      else tag = dir ? "R5" : "R4";
      check(rf[i] === e_rf[i], tag, $sformatf("reg %0d", i), 64'(rf[i]), 64'(e_rf[i]));
    end
    mem_ok = 1'b1;
    for (int j = 0; j < 256; j++) if (mem[j] !== e_mem[j]) mem_ok = 1'b0;
    check(mem_ok, poke ? "R10" : "R4", "memory image", 64'(mem_ok), 64'd1);
    @(negedge clk);
    check(!busy_o && !done_o, "R11", "idle after done", 64'({busy_o, done_o}), 64'd0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; start_i = 1'b0; dir_load_i = 1'b0; base_idx_i = '0;
    reg_mask_i = '0; base_addr_i = '0; load_stage = 1'b0; ack_all = 1'b1;
    st_base = '0;
    for (int i = 0; i < NREG; i++) st_rf[i] = '0;
    for (int j = 0; j < 256; j++) st_mem[j] = '0;
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && !mem_req_o && !rf_wr_en_o, "R1", "outputs in reset",
          64'({busy_o, done_o, mem_req_o, rf_wr_en_o}), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy_o && !done_o && !mem_req_o && !rf_wr_en_o, "R1", "outputs after reset",
          64'({busy_o, done_o, mem_req_o, rf_wr_en_o}), 64'd0);

    // Directed corners.
    run(1'b0, 3'd2, 8'h00, 1'b0);   // R8 empty store
    run(1'b1, 3'd5, 8'h00, 1'b0);   // R8 empty load
    run(1'b0, 3'd0, 8'hFF, 1'b0);   // R4 full store with base in list
    run(1'b1, 3'd3, 8'hFF, 1'b0);   // R9 full load with base in list
    run(1'b1, 3'd7, 8'h35, 1'b0);   // R5 R7 load without base
    run(1'b0, 3'd1, 8'h80, 1'b0);   // R2 single highest register
    run(1'b1, 3'd4, 8'h01, 1'b0);   // R7 single lowest register
    run(1'b1, 3'd6, 8'h66, 1'b1);   // R10 restart attempt while busy
    run(1'b0, 3'd2, 8'h5A, 1'b1);   // R10 during store
    // Random mix with wait states (R6).
    ack_all = 1'b0;
    for (int n = 0; n < 160; n++) begin
      run(1'($urandom), IW'($urandom), NREG'($urandom), 1'b0);
    end
    ack_all = 1'b1;
    for (int n = 0; n < 40; n++) begin
      run(1'($urandom), IW'($urandom), NREG'($urandom), 1'b0);
    end
    summary();
    $finish;
  end
endmodule